// File: doc/BRIEF.md
# Strip-Mined Strided Vector Address Generator

This block turns one vector memory request of arbitrary length into a series of strips that a vector register file can hold, and produces one element address per clock for each strip. A request is a total element count, a base byte address and a stride counted in elements. The stride is taken at run time from a scalar register. The strip that holds the leftover (count modulo the maximum vector length of 64) goes out first. Every strip after it is a full 64 elements long. When the count is an exact multiple of 64, the empty leftover strip is dropped.

For each element the block presents a byte address, the length of the strip that element belongs to, and markers for the first and last element of the strip. A load/store unit uses these to fill a vector register as if the data were contiguous, whatever the stride. Addresses are produced by repeated addition of the stride times the 8-byte element size, so no multiplier is needed. A ready input holds the issue stream. A single-cycle done pulse marks the end of the whole request.

Top module: `vec_strip_agen`

## Requirements
- R1: While reset is applied and after it is released, addr_valid, strip_start, strip_last and done are all 0.
- R2: A start accepted with n_elems = 0 produces a done pulse of exactly one cycle, in the cycle after start, and addr_valid never rises.
- R3: When n_elems mod 64 is nonzero, the first strip has n_elems mod 64 elements and every later strip has 64. strip_vl shows the length of the current strip on every element, and it always lies in 1..64.
- R4: When n_elems mod 64 is zero, only full strips of 64 elements are issued.
- R5: Element k (counting from 0 over the whole request) has address (base_addr + k * stride * 8) mod 2^32. stride is a 16-bit two's complement count of elements, so 16'hFFFF steps down by 8 bytes. Element 0 is at base_addr.
- R6: strip_start is 1 exactly on the first element of each strip and strip_last is 1 exactly on its last element. Both are 1 on a strip of length 1.
- R7: An element is accepted on a clock edge where addr_valid and ready are both 1. While ready is 0, addr_valid stays 1 and addr, strip_vl, strip_start and strip_last hold their values.
- R8: Exactly n_elems elements are accepted. done is a one-cycle pulse in the cycle after the final element is accepted, and addr_valid is 0 while done is 1.
- R9: A start raised while a request is in progress is ignored. The running request keeps its original count, base and stride, and no second request follows it.
- R10: After a start accepted in idle with n_elems > 0, addr_valid is 1 in the next cycle with element 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a request; taken only when idle |
| n_elems | input | 16 | Total element count of the request |
| base_addr | input | 32 | Byte address of element 0 |
| stride | input | 16 | Signed element stride (two's complement) |
| ready | input | 1 | Consumer accepts the presented element |
| addr | output | 32 | Byte address of the presented element |
| addr_valid | output | 1 | An element address is presented |
| strip_vl | output | 7 | Length of the strip the presented element belongs to |
| strip_start | output | 1 | Presented element is first of its strip |
| strip_last | output | 1 | Presented element is last of its strip |
| done | output | 1 | One-cycle pulse after the request completes |

## Verification
Counts of 1, 63 and 65 each put a short leftover strip first. A count of 65 also gives a one-element strip, where both strip markers fall on the same element. Counts of 64 and 128 have no leftover, so they show whether the empty strip is really dropped. Counts of 130 and 70 mix a leftover strip with full ones. Strides of +1, +3, zero, and negative values with base addresses near the top and bottom of the address space separate true signed accumulation from an unsigned or wrapped step. Irregular ready patterns, a zero count, and a start raised in the middle of a request show whether issue holds still, ends on a single pulse, and ignores a second start.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_RUN  = 2'd1,
    AG_FIN  = 2'd2
  } agen_state_t;

endpackage

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int MVL   = 64,
  parameter int CNT_W = 16,
  localparam int VL_W  = $clog2(MVL + 1),
  localparam int POS_W = $clog2(MVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] n_in,
  input  logic             fire,
  output logic [VL_W-1:0]  cur_vl,
  output logic             at_strip_first,
  output logic             at_strip_last,
  output logic             at_final,
  output logic             first_strip
);

  // Length of the opening strip: the leftover, or a full strip if none.
  function automatic logic [VL_W-1:0] lead_len(input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] r;
    r = n % CNT_W'(MVL);
    return (r == '0) ? VL_W'(MVL) : VL_W'(r);
  endfunction

  logic [CNT_W-1:0] rem_q;
  logic [VL_W-1:0]  vl_q;
  logic [POS_W-1:0] pos_q;
  logic             first_q;

  assign cur_vl         = vl_q;
  assign first_strip    = first_q;
  assign at_strip_first = (pos_q == '0);
  assign at_strip_last  = ({1'b0, pos_q} == (vl_q - 1'b1));
  assign at_final       = (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      vl_q    <= '0;
      pos_q   <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      rem_q   <= n_in;
      vl_q    <= lead_len(n_in);
      pos_q   <= '0;
      first_q <= 1'b1;
    end else if (fire) begin
      rem_q <= rem_q - 1'b1;
      if (at_strip_last) begin
        pos_q   <= '0;
        vl_q    <= VL_W'(MVL);
        first_q <= 1'b0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  AST_FINAL_ENDS_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && at_final |-> at_strip_last); // R3
  AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !first_strip |-> cur_vl == VL_W'(MVL)); // R4

endmodule

// File: rtl/addr_accum.sv
module addr_accum #(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int ELEM_BYTES = 8,
  localparam int SHIFT     = $clog2(ELEM_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                fire,
  output logic [ADDR_W-1:0]   addr
);

  // Byte step: sign-extended element stride scaled by the element size.
  function automatic logic [ADDR_W-1:0] step_bytes(input logic [STRIDE_W-1:0] s);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-STRIDE_W){s[STRIDE_W-1]}}, s};
    return ext << SHIFT;
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_q;

  assign addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (load) begin
      addr_q <= base;
      step_q <= step_bytes(stride);
    end else if (fire) begin
      addr_q <= addr_q + step_q;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !fire |=> $stable(addr)); // R7

endmodule

// File: rtl/vec_strip_agen.sv
module vec_strip_agen #(
  parameter int MVL        = 64,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int ELEM_BYTES = 8,
  localparam int VL_W      = $clog2(MVL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    n_elems,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                ready,
  output logic [ADDR_W-1:0]   addr,
  output logic                addr_valid,
  output logic [VL_W-1:0]     strip_vl,
  output logic                strip_start,
  output logic                strip_last,
  output logic                done
);
  import agen_pkg::*;

  agen_state_t state_q, state_d;

  logic accept_start;
  logic empty_req;
  logic fire;
  logic at_first, at_last, at_final, first_strip;
  logic [VL_W-1:0] cur_vl;

  assign accept_start = start && (state_q == AG_IDLE);
  assign empty_req    = (n_elems == '0);
  assign fire         = (state_q == AG_RUN) && ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      AG_IDLE: if (accept_start) state_d = empty_req ? AG_FIN : AG_RUN;
      AG_RUN:  if (fire && at_final) state_d = AG_FIN;
      AG_FIN:  state_d = AG_IDLE;
      default: state_d = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= AG_IDLE;
    else        state_q <= state_d;
  end

  strip_seq #(.MVL(MVL), .CNT_W(CNT_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (accept_start),
    .n_in           (n_elems),
    .fire           (fire),
    .cur_vl         (cur_vl),
    .at_strip_first (at_first),
    .at_strip_last  (at_last),
    .at_final       (at_final),
    .first_strip    (first_strip)
  );

  addr_accum #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .ELEM_BYTES(ELEM_BYTES)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_start),
    .base   (base_addr),
    .stride (stride),
    .fire   (fire),
    .addr   (addr)
  );

  assign addr_valid  = (state_q == AG_RUN);
  assign strip_vl    = cur_vl;
  assign strip_start = addr_valid && at_first;
  assign strip_last  = addr_valid && at_last;
  assign done        = (state_q == AG_FIN);

  AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (strip_vl != '0) && (strip_vl <= VL_W'(MVL))); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !ready |=> addr_valid && $stable(addr) && $stable(strip_vl)
      && $stable(strip_start) && $stable(strip_last)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid); // R2
  AST_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start && !empty_req |=> addr_valid && strip_start); // R10
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start && empty_req |=> done); // R2
  AST_START_FIRST_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> first_strip); // R3

endmodule

// File: tb/tb_vec_strip_agen.sv
`timescale 1ns/1ps
module tb_vec_strip_agen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] n_elems = '0;
  logic [31:0] base_addr = '0;
  logic [15:0] stride = '0;
  logic        ready = 1'b0;
  logic [31:0] addr;
  logic        addr_valid;
  logic [6:0]  strip_vl;
  logic        strip_start, strip_last, done;

  int nchk = 0;
  int nfail = 0;
  int wd = 0;
  bit timeout = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) timeout <= 1'b1;
  end

  vec_strip_agen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems),
    .base_addr(base_addr), .stride(stride), .ready(ready), .addr(addr),
    .addr_valid(addr_valid), .strip_vl(strip_vl), .strip_start(strip_start),
    .strip_last(strip_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int NV = 7;
  localparam logic [15:0] V_N      [0:NV-1] = '{16'd1, 16'd63, 16'd64, 16'd65, 16'd130, 16'd128, 16'd70};
  localparam logic [31:0] V_BASE   [0:NV-1] = '{32'h0000_1000, 32'h2000_0000, 32'h0000_0040, 32'hFFFF_FFF0,
                                                32'h0000_0010, 32'h8000_0000, 32'h0001_0000};
  localparam logic [15:0] V_STRIDE [0:NV-1] = '{16'd1, 16'd3, 16'hFFFF, 16'd2, 16'd0, 16'hFFFE, 16'd5};
  localparam bit          V_STALL  [0:NV-1] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit          V_POKE   [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic run_vec(input logic [15:0] n, input logic [31:0] base,
                         input logic [15:0] str, input bit stall, input bit poke);
    int k = 0;
    int cyc = 0;
    int lead;
    bit prev_stall = 1'b0;
    bit poked = 1'b0;
    logic [31:0] prev_addr = '0;
    string rq;
    @(negedge clk);
    n_elems = n; base_addr = base; stride = str; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done && !addr_valid, "R2", {addr_valid, done}, 2'b01);
      @(negedge clk);
      chk(!done && !addr_valid, "R2", {addr_valid, done}, 2'b00);
      return;
    end
    chk(addr_valid == 1'b1, "R10", addr_valid, 1);
    lead = (int'(n) % 64 == 0) ? 64 : int'(n) % 64;
    while (k < int'(n) && !timeout) begin
      int sidx, svl;
      longint ea;
      if (k < lead) begin sidx = k; svl = lead; end
      else begin sidx = (k - lead) % 64; svl = 64; end
      ea = (longint'(base) + longint'(k) * longint'($signed(str)) * 8) & 64'hFFFF_FFFF;
      chk(addr_valid == 1'b1, "R8", addr_valid, 1);
      rq = poked ? "R9" : "R5";
      chk(addr == ea[31:0], rq, addr, ea);
      rq = (int'(n) % 64 == 0) ? "R4" : "R3";
      chk(int'(strip_vl) == svl, rq, strip_vl, svl);
      chk(strip_start == (sidx == 0) && strip_last == (sidx == svl - 1), "R6",
          {strip_start, strip_last}, {(sidx == 0), (sidx == svl - 1)});
      if (prev_stall) chk(addr == prev_addr, "R7", addr, prev_addr);
      prev_addr = addr;
      if (poke && k == 3 && !poked) begin
        start = 1'b1; n_elems = 16'd5; base_addr = 32'h0; stride = 16'd7; poked = 1'b1;
      end else begin
        start = 1'b0;
      end
      ready = stall ? (((cyc * 7) % 5) > 1) : 1'b1;
      prev_stall = !ready;
      if (ready) k++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && !addr_valid, "R8", {addr_valid, done}, 2'b01);
    @(negedge clk);
    chk(!done, "R8", done, 0);
    chk(!addr_valid, "R9", addr_valid, 0);
    ready = 1'b0;
  endtask

  initial begin
    // R1: reset state
    #1;
    ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !strip_start && !strip_last && !done, "R1",
        {addr_valid, strip_start, strip_last, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_valid && !strip_start && !strip_last && !done, "R1",
        {addr_valid, strip_start, strip_last, done}, 0);
    ready = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_vec(V_N[i], V_BASE[i], V_STRIDE[i], V_STALL[i], V_POKE[i]);
    end

    // R2: empty request
    run_vec(16'd0, 32'h1234_5678, 16'd1, 1'b0, 1'b0);
    // R6: one-element strip directly after an empty request
    run_vec(16'd1, 32'hFFFF_FFF8, 16'd1, 1'b1, 1'b0);
    // R4: two full strips with stalls
    run_vec(16'd128, 32'h0000_0000, 16'd4, 1'b1, 1'b0);

    if (timeout) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule